// File: doc/BRIEF.md
# Software-access register field cell

This block is the storage for one field of a memory-mapped register. The bus side supplies an access strobe that is already decoded for this field, a write flag, and the slice of write data that covers the field. On a qualified write the field computes its new value from the old value and the data, according to a write behaviour fixed by a parameter. When a clear-on-read side effect is configured, a qualified read zeroes the field.

The hardware side sees the stored value, the AND, OR and XOR reductions of that value, a software-access pulse and a software-modify pulse. The two pulses are combinational from the access inputs and are valid in the cycle of the access. The stored value changes on the next clock edge.

Parameters set the field width, the write behaviour, the read side effect, whether a reset value exists, the reset value, and whether the field bits are declared in reverse order. One instance is placed per field, and the surrounding register block ORs the field values into its readback path.

Top module: `swfield_cell`

## Requirements
- R1: With a reset value configured, a synchronous active-low reset loads the field with the reset value.
- R2: With no reset value configured, the stored contents are kept unchanged through reset.
- R3: In plain-load mode (mode code 1), a qualified write (strobe high, write flag high) stores the write slice as is.
- R4: When the field is declared reversed, the write slice is bit-reversed (bit i taken from bit WIDTH-1-i) before the write behaviour uses it.
- R5: The write-one modes give: set (code 2) old|d, clear (code 3) old&~d, toggle (code 4) old^d.
- R6: The write-zero modes give: set (code 5) old|~d, clear (code 6) old&d, toggle (code 7) old^~d.
- R7: A read-only field (mode code 0) ignores writes: the stored value is unchanged.
- R8: With clear-on-read, a qualified read (strobe high, write flag low) makes the stored value zero. Without it, reads leave the value unchanged.
- R9: With the strobe low, the stored value is unchanged whatever the write flag and data are.
- R10: The software-access output is high exactly when the strobe is high and the write flag is low.
- R11: The software-modify output is high on writes only for a writable field with no read side effect, on any access for a writable field with clear-on-read, on reads only for a read-only field with clear-on-read, and is always low otherwise.
- R12: The reduction outputs equal the AND, OR and XOR of the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_stb | input | 1 | Decoded access strobe for this field |
| acc_wr | input | 1 | Access is a write when high, a read when low |
| wr_slice | input | WIDTH | Write data bits belonging to this field |
| fld_value | output | WIDTH | Stored field value |
| red_and | output | 1 | AND reduction of the value |
| red_or | output | 1 | OR reduction of the value |
| red_xor | output | 1 | XOR reduction of the value |
| sw_acc_pulse | output | 1 | Software read of the field this cycle |
| sw_mod_pulse | output | 1 | Software changed, or may change, the field this cycle |

## Verification
The hardest case to reach from the ports is the field without a reset value. Its contents are undefined until the first write, and keeping them through reset can only be seen by writing a known pattern, pulsing reset, and checking that the pattern is still there while the resettable fields have returned to their reset value. The bench drives one access stream into eleven instances, one per mode and side-effect mix, with a reversed and a non-resetting variant. It sweeps every 4-bit data value through idle, write and read accesses, so each write behaviour meets every old/data pair it can reach, and a bench model predicts every instance independently.

// File: rtl/swfield_pkg.sv
// Package: shared types for the software-access field cell.
// Assumes: mode codes are fixed; the register block decodes them elsewhere.
package swfield_pkg;

    // Write behaviour of a field; the code values are part of the requirements.
    typedef enum logic [2:0] {
        WM_RO   = 3'd0,   // software cannot write
        WM_LOAD = 3'd1,   // plain load of the write slice
        WM_SET1 = 3'd2,   // ones in data set bits
        WM_CLR1 = 3'd3,   // ones in data clear bits
        WM_TOG1 = 3'd4,   // ones in data toggle bits
        WM_SET0 = 3'd5,   // zeros in data set bits
        WM_CLR0 = 3'd6,   // zeros in data clear bits
        WM_TOG0 = 3'd7    // zeros in data toggle bits
    } wmode_e;

    // True when software writes can change the field.
    function automatic logic mode_writable(wmode_e m);
        return m != WM_RO;
    endfunction

endpackage

// File: rtl/swfield_align.sv
// Module: orients the write slice to the field's bit order.
// Assumes: a reversed field maps slice bit i to field bit WIDTH-1-i.
module swfield_align #(
    parameter int WIDTH    = 8,
    parameter bit REVERSED = 1'b0
) (
    input  logic [WIDTH-1:0] slice_in,
    output logic [WIDTH-1:0] slice_out
);

    generate
        if (REVERSED) begin : g_rev
            // Purpose: mirror the slice bit by bit.
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                assign slice_out[i] = slice_in[WIDTH-1-i];
            end
        end else begin : g_straight
            // Purpose: pass the slice through unchanged.
            assign slice_out = slice_in;
        end
    endgenerate

endmodule

// File: rtl/swfield_next.sv
// Module: computes the next stored value and its load enable.
// Assumes: write and read hits are mutually exclusive; a write would still
// take precedence over the read side effect if both were presented.
module swfield_next
    import swfield_pkg::*;
#(
    parameter int     WIDTH  = 8,
    parameter wmode_e WMODE  = WM_LOAD,
    parameter bit     RD_CLR = 1'b0
) (
    input  logic [WIDTH-1:0] cur_val,
    input  logic [WIDTH-1:0] wdata,
    input  logic             wr_hit,
    input  logic             rd_hit,
    output logic [WIDTH-1:0] nxt_val,
    output logic             nxt_load
);

    localparam bit WRITABLE = mode_writable(WMODE);

    logic [WIDTH-1:0] wr_val;

    // Purpose: value a write would produce under the configured behaviour.
    always_comb begin
        case (WMODE)
            WM_LOAD: wr_val = wdata;
            WM_SET1: wr_val = cur_val | wdata;
            WM_CLR1: wr_val = cur_val & ~wdata;
            WM_TOG1: wr_val = cur_val ^ wdata;
            WM_SET0: wr_val = cur_val | ~wdata;
            WM_CLR0: wr_val = cur_val & wdata;
            WM_TOG0: wr_val = cur_val ^ ~wdata;
            default: wr_val = cur_val;
        endcase
    end

    // Purpose: pick write result over read clear and raise the load enable.
    always_comb begin
        nxt_load = (WRITABLE && wr_hit) || (RD_CLR && rd_hit);
        nxt_val  = wr_hit ? wr_val : '0;
    end

endmodule

// File: rtl/swfield_store.sv
// Module: field storage register with optional reset value.
// Assumes: synchronous active-low reset; without a reset value the
// register ignores reset and only loads on its enable.
module swfield_store #(
    parameter int             WIDTH     = 8,
    parameter bit             HAS_RESET = 1'b1,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Purpose: hold the field, reset only when a reset value exists.
    always_ff @(posedge clk) begin
        if (!rst_n && HAS_RESET) begin
            q <= RESET_VAL;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/swfield_pulse.sv
// Module: derives the software-access and software-modify pulses.
// Assumes: strobe is already qualified for this field; pulses are combinational.
module swfield_pulse #(
    parameter bit WRITABLE = 1'b1,
    parameter bit RD_SIDE  = 1'b0
) (
    input  logic stb,
    input  logic wr,
    output logic acc_p,
    output logic mod_p
);

    // Purpose: a read of the field is an access.
    assign acc_p = stb && !wr;

    generate
        if (WRITABLE && !RD_SIDE) begin : g_wr_only
            // Purpose: only writes can change the field.
            assign mod_p = stb && wr;
        end else if (WRITABLE && RD_SIDE) begin : g_any
            // Purpose: both writes and reads can change the field.
            assign mod_p = stb;
        end else if (RD_SIDE) begin : g_rd_only
            // Purpose: only the read side effect changes the field.
            assign mod_p = stb && !wr;
        end else begin : g_never
            // Purpose: software cannot change the field.
            assign mod_p = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/swfield_cell.sv
// Module: one software-accessible field of a memory-mapped register.
// Assumes: acc_stb is decoded for this field; wr_slice is the field's slice
// of the bus write data; reset is synchronous and active low.
module swfield_cell
    import swfield_pkg::*;
#(
    parameter int               WIDTH     = 8,
    parameter wmode_e           WMODE     = WM_LOAD,
    parameter bit               RD_CLR    = 1'b0,
    parameter bit               HAS_RESET = 1'b1,
    parameter logic [WIDTH-1:0] RESET_VAL = '0,
    parameter bit               REVERSED  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_stb,
    input  logic             acc_wr,
    input  logic [WIDTH-1:0] wr_slice,
    output logic [WIDTH-1:0] fld_value,
    output logic             red_and,
    output logic             red_or,
    output logic             red_xor,
    output logic             sw_acc_pulse,
    output logic             sw_mod_pulse
);

    localparam bit WRITABLE = mode_writable(WMODE);

    logic [WIDTH-1:0] wdata_al;
    logic [WIDTH-1:0] nxt_val;
    logic             nxt_load;
    logic             wr_hit;
    logic             rd_hit;

    // Purpose: qualify writes and reads by the strobe.
    assign wr_hit = acc_stb && acc_wr;
    assign rd_hit = acc_stb && !acc_wr;

    swfield_align #(.WIDTH(WIDTH), .REVERSED(REVERSED)) align_i (
        .slice_in (wr_slice),
        .slice_out(wdata_al)
    );

    swfield_next #(.WIDTH(WIDTH), .WMODE(WMODE), .RD_CLR(RD_CLR)) next_i (
        .cur_val (fld_value),
        .wdata   (wdata_al),
        .wr_hit  (wr_hit),
        .rd_hit  (rd_hit),
        .nxt_val (nxt_val),
        .nxt_load(nxt_load)
    );

    swfield_store #(.WIDTH(WIDTH), .HAS_RESET(HAS_RESET), .RESET_VAL(RESET_VAL)) store_i (
        .clk  (clk),
        .rst_n(rst_n),
        .load (nxt_load),
        .d    (nxt_val),
        .q    (fld_value)
    );

    swfield_pulse #(.WRITABLE(WRITABLE), .RD_SIDE(RD_CLR)) pulse_i (
        .stb  (acc_stb),
        .wr   (acc_wr),
        .acc_p(sw_acc_pulse),
        .mod_p(sw_mod_pulse)
    );

    // Purpose: reductions of the stored value for hardware.
    assign red_and = &fld_value;
    assign red_or  = |fld_value;
    assign red_xor = ^fld_value;

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_stb |=> $stable(fld_value));

    // R11
    mod_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_mod_pulse |-> acc_stb);

    generate
        if (!WRITABLE) begin : g_ro_chk
            // R7
            ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (acc_stb && acc_wr) |=> $stable(fld_value));
        end
        if (RD_CLR) begin : g_rc_chk
            // R8
            read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (acc_stb && !acc_wr) |=> (fld_value == '0));
        end
        if (WMODE == WM_SET1 || WMODE == WM_SET0) begin : g_set_chk
            // R5
            set_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (acc_stb && acc_wr) |=> ((fld_value & $past(fld_value)) == $past(fld_value)));
        end
        if (WMODE == WM_CLR1 || WMODE == WM_CLR0) begin : g_clr_chk
            // R6
            clr_adds_no_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (acc_stb && acc_wr) |=> ((fld_value | $past(fld_value)) == $past(fld_value)));
        end
    endgenerate

endmodule

// File: tb/swfield_cell_tb_top.sv
`timescale 1ns/1ps
module swfield_cell_tb_top;
    import swfield_pkg::*;

    localparam int W    = 4;
    localparam int NCFG = 11;
    localparam logic [W-1:0] RV = 4'hA;

    // Configuration table: 0..1 read-only, 2..3 load, 4..9 set/clear/toggle,
    // 10 load without reset value.
    function automatic wmode_e cfg_mode(int c);
        case (c)
            0, 1:     return WM_RO;
            2, 3, 10: return WM_LOAD;
            4:        return WM_SET1;
            5:        return WM_CLR1;
            6:        return WM_TOG1;
            7:        return WM_SET0;
            8:        return WM_CLR0;
            default:  return WM_TOG0;
        endcase
    endfunction
    function automatic bit cfg_rdclr(int c);  return (c == 1) || (c == 3); endfunction
    function automatic bit cfg_rev(int c);    return c == 3;               endfunction
    function automatic bit cfg_hasrst(int c); return c != 10;              endfunction

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb = 1'b0;
    logic wr = 1'b0;
    logic [W-1:0] wd = '0;
    logic [W-1:0] val_w [NCFG];
    logic and_w [NCFG];
    logic or_w  [NCFG];
    logic xor_w [NCFG];
    logic acc_w [NCFG];
    logic mod_w [NCFG];

    always #2 clk = ~clk;

    for (genvar c = 0; c < NCFG; c++) begin : g_cfg
        swfield_cell #(
            .WIDTH(W), .WMODE(cfg_mode(c)), .RD_CLR(cfg_rdclr(c)),
            .HAS_RESET(cfg_hasrst(c)), .RESET_VAL(RV), .REVERSED(cfg_rev(c))
        ) dut_i (
            .clk(clk), .rst_n(rst_n), .acc_stb(stb), .acc_wr(wr), .wr_slice(wd),
            .fld_value(val_w[c]), .red_and(and_w[c]), .red_or(or_w[c]),
            .red_xor(xor_w[c]), .sw_acc_pulse(acc_w[c]), .sw_mod_pulse(mod_w[c])
        );
    end

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] mdl [NCFG];
    bit known [NCFG];

    task automatic chk(bit ok, string tag, int c, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cfg %0d: actual %0h expected %0h", tag, c, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rev(logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return r;
    endfunction

    // Value and reduction checks for every known instance.
    task automatic check_vals(string vtag);
        for (int c = 0; c < NCFG; c++) begin
            if (known[c]) begin
                chk(val_w[c] == mdl[c], vtag, c, val_w[c], mdl[c]);
                chk(and_w[c] == &mdl[c], "R12 and", c, and_w[c], &mdl[c]);
                chk(or_w[c]  == |mdl[c], "R12 or",  c, or_w[c],  |mdl[c]);
                chk(xor_w[c] == ^mdl[c], "R12 xor", c, xor_w[c], ^mdl[c]);
            end
        end
    endtask

    // One access: drive at negedge, check pulses, then check value after edge.
    task automatic op(bit s, bit w, logic [W-1:0] d);
        @(negedge clk);
        stb = s; wr = w; wd = d;
        #1;
        for (int c = 0; c < NCFG; c++) begin
            bit wrt = cfg_mode(c) != WM_RO;
            bit rc  = cfg_rdclr(c);
            bit em;
            if (wrt && !rc)      em = s && w;
            else if (wrt && rc)  em = s;
            else if (rc)         em = s && !w;
            else                 em = 1'b0;
            chk(acc_w[c] == (s && !w), "R10", c, acc_w[c], s && !w);
            chk(mod_w[c] == em, "R11", c, mod_w[c], em);
        end
        @(posedge clk);
        #1;
        for (int c = 0; c < NCFG; c++) begin
            logic [W-1:0] a = cfg_rev(c) ? rev(d) : d;
            logic [W-1:0] o = mdl[c];
            if (s && w) begin
                case (cfg_mode(c))
                    WM_LOAD: begin mdl[c] = a; known[c] = 1'b1; end
                    WM_SET1: mdl[c] = o | a;
                    WM_CLR1: mdl[c] = o & ~a;
                    WM_TOG1: mdl[c] = o ^ a;
                    WM_SET0: mdl[c] = o | ~a;
                    WM_CLR0: mdl[c] = o & a;
                    WM_TOG0: mdl[c] = o ^ ~a;
                    default: mdl[c] = o;
                endcase
            end else if (s && cfg_rdclr(c)) begin
                mdl[c] = '0;
                known[c] = 1'b1;
            end
        end
        if (!s)        check_vals("R9 idle");
        else if (!w)   check_vals("R8 read");
        else           check_vals("R3 R4 R5 R6 R7 write");
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        rst_n = 1'b0; stb = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        for (int c = 0; c < NCFG; c++) begin
            if (cfg_hasrst(c)) begin mdl[c] = RV; known[c] = 1'b1; end
        end
        check_vals(tag);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCFG; c++) begin mdl[c] = '0; known[c] = 1'b0; end
        // R1: reset state of resettable instances
        do_reset("R1 reset");
        // Sweep every data value through idle, write, read and inverted write.
        for (int r = 0; r < 3; r++) begin
            for (int d = 0; d < 16; d++) begin
                op(1'b0, d[0], 4'(d));
                op(1'b1, 1'b1, 4'(d));
                op(1'b1, 1'b0, 4'(d));
                op(1'b1, 1'b1, ~4'(d));
                op(1'b0, 1'b1, ~4'(d));
            end
        end
        // R2: non-resetting field keeps a known pattern through reset
        op(1'b1, 1'b1, 4'h5);
        do_reset("R2 R1 reset retention");
        op(1'b0, 1'b0, 4'h0);
        op(1'b1, 1'b1, 4'h3);
        do_reset("R2 second retention");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule